// File: doc/BRIEF.md
# Nibble Arithmetic and Logic Unit with Decimal Digits

This is a purely combinational unit that works on two 4-bit operands. A 4-bit operation code selects one of sixteen functions: binary and decimal (BCD) add and subtract, bitwise logic, increment, pass-through, two constant-zero outputs, multiplication and division. The unit returns a 4-bit result and a flag word `{N,Z,V,C}`, where bit 3 is N and bit 0 is C.

The enclosing processor holds the flag register. It feeds the stored flags back through `flags_i` and stores `flags_o` at the end of each step. The carry input lets multi-nibble binary words and multi-digit decimal numbers be processed one nibble at a time.

Decimal operations keep the stored N, Z and V values and replace only the carry. One operation loads the whole flag word from operand B. Division and remainder by zero return a saturated value.

Top module: `alu4_core`

## Requirements
- R1: `op_i` selects the function by code: 0 decimal add, 1 decimal subtract, 2 AND, 3 OR, 4 XOR, 5 increment A, 6 zero result with flags loaded from B, 7 zero result, 8 binary add, 9 binary subtract, 10 pass A, 11 pass B, 12 product high nibble, 13 product low nibble, 14 quotient, 15 remainder.
- R2: Binary add (code 8) returns the low 4 bits of A+B+carry_i. C is the carry out, and V is set on two's-complement overflow.
- R3: Binary subtract (code 9) returns A-B-(1-carry_i), so carry_i=1 means no borrow in. C=1 when no borrow results, and V is set on two's-complement overflow.
- R4: Increment (code 5) returns A+1 and ignores carry_i. C is set only for A=1111, and V is set only for A=0111.
- R5: AND, OR, XOR, pass A and pass B (codes 2, 3, 4, 10, 11) give V=0 and C=0.
- R6: For every code except 0, 1 and 6, N equals result bit 3 and Z is 1 exactly when the result is 0000.
- R7: Code 6 returns 0000 and sets flags_o to B, so N=B[3], Z=B[2], V=B[1] and C=B[0].
- R8: Code 7 returns 0000 with flags 0100 (only Z set).
- R9: Codes 12 and 13 return bits 7..4 and bits 3..0 of the 8-bit unsigned product A*B, with V=0 and C=0.
- R10: For B other than 0, code 14 returns floor(A/B) and code 15 returns A mod B (both unsigned), with V=0 and C=0.
- R11: For B=0, codes 14 and 15 return 1111 with flags N=1, Z=0, V=1, C=0.
- R12: Decimal add (code 0) on digits 0..9 forms S=A+B+carry_i. If S>9 it returns S-10 with C=1, otherwise S with C=0.
- R13: Decimal subtract (code 1) on digits 0..9 forms D=A-B-(1-carry_i). If D<0 it returns D+10 with C=0 (borrow), otherwise D with C=1.
- R14: For codes 0 and 1, flags_o bits 3..1 (N, Z, V) equal flags_i bits 3..1, whatever the result is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| carry_i | input | 1 | Carry in; acts as "no borrow" for subtraction |
| op_i | input | 4 | Operation code |
| flags_i | input | 4 | Stored flags {N,Z,V,C}, passed through by decimal operations |
| result_o | output | 4 | Result nibble |
| flags_o | output | 4 | New flags {N,Z,V,C} |

## Verification
The hardest cases to reach are the decimal operations. Their flag outputs must show the stored flags, not flags derived from the result. A Z input that disagrees with the result is therefore the only way to catch a design that recomputes Z. The stimulus drives `flags_i` from a pattern that varies independently of the operands, and it also sets a stored Z=1 on a non-zero decimal result. The decimal boundaries need the sum at 9 and at 10, and a borrow produced only by carry_i=0. All digit pairs are swept with both carry values so that both boundaries appear. Divide-by-zero is driven with several dividends.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

   typedef enum logic [3:0] {
      OP_DADD  = 4'd0,
      OP_DSUB  = 4'd1,
      OP_AND   = 4'd2,
      OP_OR    = 4'd3,
      OP_XOR   = 4'd4,
      OP_INC   = 4'd5,
      OP_FLDB  = 4'd6,
      OP_ZERO  = 4'd7,
      OP_ADD   = 4'd8,
      OP_SUB   = 4'd9,
      OP_PASSA = 4'd10,
      OP_PASSB = 4'd11,
      OP_MULH  = 4'd12,
      OP_MULL  = 4'd13,
      OP_DIV   = 4'd14,
      OP_MOD   = 4'd15
   } alu_op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_V = 1;
   localparam int FLAG_C = 0;
   localparam int FLAG_W = 4;

   function automatic logic is_decimal(alu_op_e op);
      return (op == OP_DADD) || (op == OP_DSUB);
   endfunction

endpackage

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
   parameter int W = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         carry_i,
   input  logic         sub_i,
   input  logic         inc_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);
   logic [W-1:0] opnd;
   logic         cin_eff;
   logic [W:0]   wide;

   always_comb begin
      opnd    = sub_i ? ~b_i : b_i;
      cin_eff = carry_i;
      if (inc_i) begin
         opnd    = W'(1);
         cin_eff = 1'b0;
      end
   end

   assign wide   = {1'b0, a_i} + {1'b0, opnd} + {{W{1'b0}}, cin_eff};
   assign sum_o  = wide[W-1:0];
   assign cout_o = wide[W];
   assign ovf_o  = (a_i[W-1] == opnd[W-1]) && (sum_o[W-1] != a_i[W-1]);

endmodule

// File: rtl/alu4_bcd.sv
module alu4_bcd #(
   parameter int DW = 4
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic          carry_i,
   input  logic          sub_i,
   output logic [DW-1:0] digit_o,
   output logic          cout_o
);
   localparam int TW   = DW + 2;
   localparam int BASE = 10;

   logic signed [TW-1:0] sum_t;
   logic signed [TW-1:0] dif_t;
   logic signed [TW-1:0] fix_t;

   if (DW != 4) begin : g_bad_width
      $error("alu4_bcd: a decimal digit needs exactly 4 bits");
   end

   assign sum_t = TW'(a_i) + TW'(b_i) + TW'(carry_i);
   assign dif_t = TW'(a_i) - TW'(b_i) - TW'(!carry_i);

   always_comb begin
      if (sub_i) begin
         cout_o = ~dif_t[TW-1];
         fix_t  = dif_t[TW-1] ? dif_t + TW'(BASE) : dif_t;
      end else begin
         cout_o = (sum_t > TW'(BASE - 1));
         fix_t  = cout_o ? sum_t - TW'(BASE) : sum_t;
      end
      digit_o = fix_t[DW-1:0];
   end

   always_comb begin
      if (!$isunknown({a_i, b_i, carry_i, sub_i}) && a_i <= DW'(9) && b_i <= DW'(9)) begin
         assert_digit_R12: assert (digit_o <= DW'(9))
            else $error("R12/R13: decimal digit out of range %0d", digit_o);
      end
   end

endmodule

// File: rtl/alu4_muldiv.sv
module alu4_muldiv #(
   parameter int W         = 4,
   parameter int DIV_STYLE = 1
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [2*W-1:0] prod_o,
   output logic [W-1:0]   quot_o,
   output logic [W-1:0]   rem_o
);
   localparam int PW = 2 * W;

   logic [PW-1:0] acc [0:W];
   assign acc[0] = '0;

   for (genvar i = 0; i < W; i++) begin : g_mul
      logic [PW-1:0] part;
      assign part     = b_i[i] ? (PW'(a_i) << i) : '0;
      assign acc[i+1] = acc[i] + part;
   end
   assign prod_o = acc[W];

   if (DIV_STYLE == 1) begin : g_div_array
      logic [W:0]   part_rem [0:W];
      logic [W-1:0] qbits;
      assign part_rem[0] = '0;
      for (genvar i = 0; i < W; i++) begin : g_stage
         logic [W:0] shifted;
         logic [W:0] trial;
         assign shifted       = {part_rem[i][W-1:0], a_i[W-1-i]};
         assign trial         = shifted - {1'b0, b_i};
         assign qbits[W-1-i]  = ~trial[W];
         assign part_rem[i+1] = trial[W] ? shifted : trial;
      end
      assign quot_o = qbits;
      assign rem_o  = part_rem[W][W-1:0];

      always_comb begin
         if (!$isunknown({a_i, b_i}) && b_i != '0) begin
            assert_divrecon_R10: assert ((PW'(quot_o) * PW'(b_i) + PW'(rem_o)) == PW'(a_i)
                                         && rem_o < b_i)
               else $error("R10: quotient %0d remainder %0d do not rebuild %0d", quot_o, rem_o, a_i);
         end
      end
   end else if (DIV_STYLE == 0) begin : g_div_op
      assign quot_o = (b_i == '0) ? '1 : a_i / b_i;
      assign rem_o  = (b_i == '0) ? '1 : a_i % b_i;
   end else begin : g_div_bad
      $error("alu4_muldiv: DIV_STYLE must be 0 or 1");
   end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
   import alu4_pkg::*;
#(
   parameter int W         = 4,
   parameter int DIV_STYLE = 1
) (
   input  logic [W-1:0]      a_i,
   input  logic [W-1:0]      b_i,
   input  logic              carry_i,
   input  logic [3:0]        op_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [W-1:0]      result_o,
   output logic [FLAG_W-1:0] flags_o
);
   localparam int PW = 2 * W;

   if (W != FLAG_W) begin : g_bad_width
      $error("alu4_core: operand width must match the 4-bit flag word");
   end

   alu_op_e       op;
   logic [W-1:0]  as_sum, bcd_digit, quot, rem;
   logic          as_cout, as_ovf, bcd_cout;
   logic [PW-1:0] prod;
   logic          ovf_sel, cry_sel;

   assign op = alu_op_e'(op_i);

   alu4_addsub #(.W(W)) u_addsub (
      .a_i    (a_i),
      .b_i    (b_i),
      .carry_i(carry_i),
      .sub_i  (op == OP_SUB),
      .inc_i  (op == OP_INC),
      .sum_o  (as_sum),
      .cout_o (as_cout),
      .ovf_o  (as_ovf)
   );

   alu4_bcd #(.DW(W)) u_bcd (
      .a_i    (a_i),
      .b_i    (b_i),
      .carry_i(carry_i),
      .sub_i  (op == OP_DSUB),
      .digit_o(bcd_digit),
      .cout_o (bcd_cout)
   );

   alu4_muldiv #(.W(W), .DIV_STYLE(DIV_STYLE)) u_muldiv (
      .a_i   (a_i),
      .b_i   (b_i),
      .prod_o(prod),
      .quot_o(quot),
      .rem_o (rem)
   );

   always_comb begin
      result_o = '0;
      ovf_sel  = 1'b0;
      cry_sel  = 1'b0;
      case (op)
         OP_DADD, OP_DSUB: result_o = bcd_digit;
         OP_AND:           result_o = a_i & b_i;
         OP_OR:            result_o = a_i | b_i;
         OP_XOR:           result_o = a_i ^ b_i;
         OP_INC, OP_ADD, OP_SUB: begin
            result_o = as_sum;
            ovf_sel  = as_ovf;
            cry_sel  = as_cout;
         end
         OP_FLDB, OP_ZERO: result_o = '0;
         OP_PASSA:         result_o = a_i;
         OP_PASSB:         result_o = b_i;
         OP_MULH:          result_o = prod[PW-1:W];
         OP_MULL:          result_o = prod[W-1:0];
         OP_DIV, OP_MOD: begin
            if (b_i == '0) begin
               result_o = '1;
               ovf_sel  = 1'b1;
            end else begin
               result_o = (op == OP_DIV) ? quot : rem;
            end
         end
         default: result_o = '0;
      endcase
   end

   always_comb begin
      if (is_decimal(op)) begin
         flags_o         = flags_i;
         flags_o[FLAG_C] = bcd_cout;
      end else if (op == OP_FLDB) begin
         flags_o = b_i;
      end else begin
         flags_o[FLAG_N] = result_o[W-1];
         flags_o[FLAG_Z] = (result_o == '0);
         flags_o[FLAG_V] = ovf_sel;
         flags_o[FLAG_C] = cry_sel;
      end
   end

   always_comb begin
      if (!$isunknown({a_i, b_i, carry_i, op_i, flags_i})) begin
         if (op == OP_FLDB) begin
            assert_fldb_R7: assert (result_o == '0 && flags_o == b_i)
               else $error("R7: flag load from B gave y=%h f=%b", result_o, flags_o);
         end
         if (is_decimal(op)) begin
            assert_decflags_R14: assert (flags_o[3:1] == flags_i[3:1])
               else $error("R14: decimal op altered N/Z/V");
         end
         if ((op == OP_DIV || op == OP_MOD) && b_i == '0) begin
            assert_divzero_R11: assert (result_o == '1 && flags_o[FLAG_V])
               else $error("R11: divide by zero gave y=%h f=%b", result_o, flags_o);
         end
         if (!is_decimal(op) && op != OP_FLDB) begin
            assert_zflag_R6: assert (flags_o[FLAG_Z] == (result_o == '0)
                                     && flags_o[FLAG_N] == result_o[W-1])
               else $error("R6: N/Z disagree with result %h", result_o);
         end
      end
   end

endmodule

// File: tb/alu4_core_tb.sv
module alu4_core_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a_i = '0, b_i = '0, op_i = '0, flags_i = '0;
   logic       carry_i = 1'b0;
   logic [3:0] result_o, flags_o;
   int         n_tests = 0;
   int         n_fail = 0;
   int         cycles = 0;

   always #5 clk = ~clk;

   alu4_core u_dut (
      .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .op_i(op_i),
      .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
   );

   function automatic int sx(int v);
      return (v > 7) ? v - 16 : v;
   endfunction

   function automatic logic [7:0] model(int op, int a, int b, int c, int fl);
      int y, v, cy, t, s;
      y = 0; v = 0; cy = 0;
      case (op)
         0: begin t = a + b + c; if (t > 9) begin y = t - 10; cy = 1; end else y = t; end
         1: begin t = a - b - (1 - c); if (t < 0) begin y = t + 10; cy = 0; end else begin y = t; cy = 1; end end
         2: y = a & b;
         3: y = a | b;
         4: y = a ^ b;
         5: begin t = a + 1; y = t & 15; cy = t >> 4; v = (a == 7) ? 1 : 0; end
         6: return {4'b0000, b[3:0]};
         7: y = 0;
         8: begin t = a + b + c; y = t & 15; cy = t >> 4; s = sx(a) + sx(b) + c; v = (s > 7 || s < -8) ? 1 : 0; end
         9: begin t = a + (15 - b) + c; y = t & 15; cy = t >> 4; s = sx(a) - sx(b) - (1 - c); v = (s > 7 || s < -8) ? 1 : 0; end
         10: y = a;
         11: y = b;
         12: y = (a * b) >> 4;
         13: y = (a * b) & 15;
         14: if (b == 0) begin y = 15; v = 1; end else y = a / b;
         default: if (b == 0) begin y = 15; v = 1; end else y = a % b;
      endcase
      if (op <= 1) return {y[3:0], fl[3], fl[2], fl[1], cy[0]};
      return {y[3:0], y[3], (y == 0) ? 1'b1 : 1'b0, v[0], cy[0]};
   endfunction

   task automatic apply(int op, int a, int b, int c, int fl);
      op_i = op[3:0]; a_i = a[3:0]; b_i = b[3:0]; carry_i = c[0]; flags_i = fl[3:0];
      #2;
   endtask

   task automatic check(string tag, logic [7:0] exp);
      n_tests++;
      if ({result_o, flags_o} !== exp) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%0d b=%0d cin=%0b fi=%b: got y=%h f=%b, expected y=%h f=%b",
                  tag, op_i, a_i, b_i, carry_i, flags_i, result_o, flags_o, exp[7:4], exp[3:0]);
      end
   endtask

   task automatic run(string tag, int op, int a, int b, int c, int fl);
      apply(op, a, b, c, fl);
      check(tag, model(op, a, b, c, fl));
   endtask

   task automatic t_idle_R12();
      run("R12 idle inputs", 0, 0, 0, 0, 0);
      check("R12 idle inputs", 8'h00);
   endtask

   task automatic t_codes_R1();
      for (int op = 0; op < 16; op++) run("R1 code map", op, 6, 3, 1, 4'b1010);
   endtask

   task automatic t_add_R2();
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++) run("R2 binary add", 8, a, b, c, 0);
   endtask

   task automatic t_sub_R3();
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++) run("R3 binary sub", 9, a, b, c, 0);
   endtask

   task automatic t_inc_R4();
      for (int a = 0; a < 16; a++)
         for (int c = 0; c < 2; c++) run("R4 increment", 5, a, 9, c, 15);
      apply(5, 15, 0, 1, 0); check("R4 wrap", 8'h05);
      apply(5, 7, 0, 0, 0);  check("R4 overflow", 8'h8A);
   endtask

   task automatic t_logic_R5();
      int ops[5] = '{2, 3, 4, 10, 11};
      foreach (ops[k])
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b += 3) run("R5 logic/pass", ops[k], a, b, 1, 15);
   endtask

   task automatic t_nz_R6();
      apply(8, 8, 8, 0, 0); check("R6 zero+carry+ovf", 8'h07);
      apply(9, 3, 5, 1, 0); check("R6 negative", 8'hE8);
      apply(2, 5, 10, 0, 0); check("R6 and zero", 8'h04);
   endtask

   task automatic t_fldb_R7();
      for (int b = 0; b < 16; b++) run("R7 flag load", 6, 15 - b, b, b & 1, 15 - b);
   endtask

   task automatic t_zero_R8();
      apply(7, 13, 6, 1, 11); check("R8 zero op", 8'h04);
   endtask

   task automatic t_mul_R9();
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) begin
            run("R9 mul high", 12, a, b, 0, 0);
            run("R9 mul low", 13, a, b, 0, 0);
         end
   endtask

   task automatic t_div_R10();
      for (int a = 0; a < 16; a++)
         for (int b = 1; b < 16; b++) begin
            run("R10 quotient", 14, a, b, 1, 0);
            run("R10 remainder", 15, a, b, 1, 0);
         end
   endtask

   task automatic t_div0_R11();
      for (int a = 0; a < 16; a += 5) begin
         apply(14, a, 0, 0, 0); check("R11 div by zero", 8'hFA);
         apply(15, a, 0, 1, 5); check("R11 mod by zero", 8'hFA);
      end
   endtask

   task automatic t_dadd_R12();
      for (int a = 0; a < 10; a++)
         for (int b = 0; b < 10; b++)
            for (int c = 0; c < 2; c++) run("R12 decimal add", 0, a, b, c, (a * 3 + b + c) & 15);
      apply(0, 4, 5, 0, 0); check("R12 sum nine", 8'h90);
      apply(0, 4, 5, 1, 0); check("R12 sum ten", 8'h01);
   endtask

   task automatic t_dsub_R13();
      for (int a = 0; a < 10; a++)
         for (int b = 0; b < 10; b++)
            for (int c = 0; c < 2; c++) run("R13 decimal sub", 1, a, b, c, (a + b * 5 + c) & 15);
      apply(1, 3, 3, 0, 0); check("R13 borrow in", 8'h90);
      apply(1, 3, 3, 1, 0); check("R13 no borrow", 8'h01);
   endtask

   task automatic t_decflags_R14();
      apply(0, 5, 5, 0, 4'b1110); check("R14 keeps NZV", 8'h0F);
      apply(0, 2, 3, 0, 4'b0100); check("R14 stale Z kept", 8'h54);
      apply(1, 2, 7, 1, 4'b1011); check("R14 sub keeps NZV", 8'h5A);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got %0d cycles, expected at most 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_idle_R12();
      t_codes_R1();
      t_add_R2();
      t_sub_R3();
      t_inc_R4();
      t_logic_R5();
      t_nz_R6();
      t_fldb_R7();
      t_zero_R8();
      t_mul_R9();
      t_div_R10();
      t_div0_R11();
      t_dadd_R12();
      t_dsub_R13();
      t_decflags_R14();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule